// File: doc/BRIEF.md
# Windowed Image Scan-Out Controller

The block produces 640x480, 60 Hz raster timing from a 100 MHz system clock and shows a 300x300 picture, held in an external synchronous memory, inside a fixed rectangle of the screen. The pixel rate is a quarter of the system clock. It comes from a clock enable, so every register stays on the one system clock. Everything outside the rectangle, including all blanking, is driven black.

The block drives a linear read address to the image memory and takes back a 12-bit word one clock later. The address only moves forward while the beam is inside the picture, so no pixel is shown twice. It returns to zero at the end of every frame. Colour, horizontal sync and vertical sync are all registered at the same pixel-enable edge, so they leave the block one pixel period after the position they describe.

The screen geometry, the picture size, the divide ratio and the window origin are all parameters. The defaults give the standard 640x480 timing with the picture centred at (170, 90).

Top module: `img_window_scan`

## Requirements
- R1: A pixel enable occurs once every DIV system clocks (default 4). The counters and every output change only at the clock edge that follows an enable.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP pixel periods (default 640+16+96+48 = 800). Positions are numbered from 0 at the first visible pixel. hSyncN is low exactly for positions H_VIS+H_FP to H_VIS+H_FP+H_SYNC-1 and high for all other positions.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 480+10+2+33 = 525). The line count advances when the horizontal count wraps. vSyncN is low exactly for lines V_VIS+V_FP to V_VIS+V_FP+V_SYNC-1.
- R4: While rstN is low, hSyncN and vSyncN are high, red, green and blue are zero, and memAddr is zero.
- R5: Every position outside the window X0 ≤ h < X0+IMG_W, Y0 ≤ v < Y0+IMG_H shows zero on red, green and blue. This includes all blanking positions.
- R6: A position inside the window shows the memory word at that position's address. Red is word bits 11:8, green is bits 7:4 and blue is bits 3:0.
- R7: While the beam is at window position (h, v), memAddr equals (v−Y0)·IMG_W + (h−X0). The colour, hSyncN and vSyncN for a position all appear together one pixel period later.
- R8: memAddr is zero at position (0, 0) of every frame and never exceeds IMG_W·IMG_H−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rstN | input | 1 | Synchronous reset, active low |
| memData | input | 12 | Word returned by the image memory one clock after memAddr |
| memAddr | output | AW (17) | Linear image memory read address |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| red | output | 4 | Red intensity |
| green | output | 4 | Green intensity |
| blue | output | 4 | Blue intensity |

## Verification
The hardest cases to reach at full size are the frame wrap and the window edges. One full-size frame takes over 1.6 million system clocks, so many frames, with the address rewind checked at each one, would not fit in a reasonable run. The bench therefore builds a scaled-down screen: a 24x17 raster with a 5x4 window. It sweeps every clock of more than three frames. At each clock the expected sync levels, colour and address are worked out from the clock count alone. This covers every window corner, every blanking region and three address rewinds.

// File: rtl/img_scan_pkg.sv
package img_scan_pkg;
  // Strobes passed from the raster timing to the pixel datapath.
  typedef struct packed {
    logic pixEn;     // one-clock pixel enable
    logic inWin;     // current position lies inside the image window
    logic hSyncOn;   // current position lies in the horizontal sync interval
    logic vSyncOn;   // current line lies in the vertical sync interval
    logic frameEnd;  // current position is the last of the frame
  } scanStrobes_t;
endpackage

// File: rtl/scan_timing.sv
module scan_timing
  import img_scan_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int IMG_W  = 300,
  parameter int IMG_H  = 300,
  parameter int X0     = 170,
  parameter int Y0     = 90
) (
  input  logic         clk,
  input  logic         rstN,
  output scanStrobes_t strb
);
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [HW-1:0] H_LAST   = HW'(HT - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(VT - 1);
  localparam logic [HW-1:0] HS_LO    = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_HI    = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_LO    = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_HI    = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [HW-1:0] WX_LO    = HW'(X0);
  localparam logic [HW-1:0] WX_HI    = HW'(X0 + IMG_W);
  localparam logic [VW-1:0] WY_LO    = VW'(Y0);
  localparam logic [VW-1:0] WY_HI    = VW'(Y0 + IMG_H);

  logic [DW-1:0] divCnt;
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          pixEn, hLast, vLast;

  assign pixEn = (divCnt == DIV_LAST);
  assign hLast = (hCnt == H_LAST);
  assign vLast = (vCnt == V_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      hCnt   <= '0;
      vCnt   <= '0;
    end else begin
      divCnt <= pixEn ? '0 : divCnt + 1'b1;
      if (pixEn) begin
        hCnt <= hLast ? '0 : hCnt + 1'b1;
        if (hLast) vCnt <= vLast ? '0 : vCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.pixEn    = pixEn;
    strb.inWin    = (hCnt >= WX_LO) && (hCnt < WX_HI) &&
                    (vCnt >= WY_LO) && (vCnt < WY_HI);
    strb.hSyncOn  = (hCnt >= HS_LO) && (hCnt < HS_HI);
    strb.vSyncOn  = (vCnt >= VS_LO) && (vCnt < VS_HI);
    strb.frameEnd = hLast && vLast;
  end
endmodule

// File: rtl/scan_pixel_path.sv
module scan_pixel_path
  import img_scan_pkg::*;
#(
  parameter int IMG_W = 300,
  parameter int IMG_H = 300,
  parameter int AW    = $clog2(IMG_W * IMG_H)
) (
  input  logic          clk,
  input  logic          rstN,
  input  scanStrobes_t  strb,
  input  logic [11:0]   memData,
  output logic [AW-1:0] memAddr,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic [3:0]    red,
  output logic [3:0]    green,
  output logic [3:0]    blue
);
  localparam logic [AW-1:0] ADDR_LAST = AW'(IMG_W * IMG_H - 1);

  logic [AW-1:0] addrQ;
  logic [11:0]   pixQ;

  // Address of the pixel under the beam; advances once per window pixel.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strb.pixEn) begin
      if (strb.frameEnd)
        addrQ <= '0;
      else if (strb.inWin && (addrQ != ADDR_LAST))
        addrQ <= addrQ + 1'b1;
    end
  end

  // Output stage: data for the current position is ready by the period end.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixQ   <= '0;
      hSyncN <= 1'b1;
      vSyncN <= 1'b1;
    end else if (strb.pixEn) begin
      pixQ   <= strb.inWin ? memData : 12'h000;
      hSyncN <= ~strb.hSyncOn;
      vSyncN <= ~strb.vSyncOn;
    end
  end

  assign memAddr = addrQ;
  assign red     = pixQ[11:8];
  assign green   = pixQ[7:4];
  assign blue    = pixQ[3:0];
endmodule

// File: rtl/img_window_scan.sv
module img_window_scan
  import img_scan_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int IMG_W  = 300,
  parameter int IMG_H  = 300,
  parameter int X0     = 170,
  parameter int Y0     = 90,
  parameter int AW     = $clog2(IMG_W * IMG_H)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [11:0]   memData,
  output logic [AW-1:0] memAddr,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic [3:0]    red,
  output logic [3:0]    green,
  output logic [3:0]    blue
);
  scanStrobes_t strb;

  scan_timing #(
    .DIV(DIV), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .IMG_W(IMG_W), .IMG_H(IMG_H), .X0(X0), .Y0(Y0)
  ) u_timing (
    .clk (clk),
    .rstN(rstN),
    .strb(strb)
  );

  scan_pixel_path #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .memData(memData),
    .memAddr(memAddr),
    .hSyncN (hSyncN),
    .vSyncN (vSyncN),
    .red    (red),
    .green  (green),
    .blue   (blue)
  );
endmodule

// File: rtl/img_window_scan_chk.sv
module img_window_scan_chk #(
  parameter int IMG_W = 300,
  parameter int IMG_H = 300,
  parameter int AW    = $clog2(IMG_W * IMG_H)
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixEn,
  input logic          frameEnd,
  input logic [AW-1:0] memAddr,
  input logic          hSyncN,
  input logic          vSyncN,
  input logic [3:0]    red,
  input logic [3:0]    green,
  input logic [3:0]    blue
);
  localparam logic [AW-1:0] ADDR_LAST = AW'(IMG_W * IMG_H - 1);

  assert_pix_rate_R1: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> !pixEn);

  assert_hold_between_enables_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixEn) |-> $stable({hSyncN, vSyncN, red, green, blue}));

  assert_black_in_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!hSyncN || !vSyncN) |-> ({red, green, blue} == 12'h000));

  assert_addr_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    memAddr <= ADDR_LAST);

  assert_addr_rewind_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && frameEnd) |=> (memAddr == '0));
endmodule

bind img_window_scan img_window_scan_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pixEn   (strb.pixEn),
  .frameEnd(strb.frameEnd),
  .memAddr (memAddr),
  .hSyncN  (hSyncN),
  .vSyncN  (vSyncN),
  .red     (red),
  .green   (green),
  .blue    (blue)
);

// File: tb/img_window_scan_bench.sv
module img_window_scan_bench;
  localparam int DIV = 4;
  localparam int H_VIS = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_VIS = 12, V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int IMG_W = 5, IMG_H = 4, X0 = 6, Y0 = 3;
  localparam int AW = $clog2(IMG_W * IMG_H);
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME = HT * VT;
  localparam int NPIX = IMG_W * IMG_H;
  localparam int NCLK = 3 * FRAME * DIV + 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] memData;
  logic [AW-1:0] memAddr;
  logic hSyncN, vSyncN;
  logic [3:0] red, green, blue;
  logic [11:0] memArr [NPIX];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  initial begin
    for (int a = 0; a < NPIX; a++) memArr[a] = 12'((a * 173 + 91) ^ (a << 7));
  end

  always_ff @(posedge clk)
    memData <= (int'(memAddr) < NPIX) ? memArr[memAddr] : 12'hxxx;

  img_window_scan #(
    .DIV(DIV), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .IMG_W(IMG_W), .IMG_H(IMG_H), .X0(X0), .Y0(Y0)
  ) u_img_window_scan (
    .clk(clk), .rstN(rstN), .memData(memData), .memAddr(memAddr),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .red(red), .green(green), .blue(blue)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic inWin(int h, int v);
    return (h >= X0) && (h < X0 + IMG_W) && (v >= Y0) && (v < Y0 + IMG_H);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset values
    check(hSyncN === 1'b1, "R4 hSyncN in reset", int'(hSyncN), 1);
    check(vSyncN === 1'b1, "R4 vSyncN in reset", int'(vSyncN), 1);
    check({red, green, blue} === 12'h000, "R4 colour in reset", int'({red, green, blue}), 0);
    check(memAddr === '0, "R4 address in reset", int'(memAddr), 0);
    rstN = 1'b1;
    for (int e = 1; e <= NCLK; e++) begin
      @(negedge clk);
      begin
        int p, ph, pv, idx, h, v, expAddr, expCol;
        logic expHs, expVs;
        // Position under the beam now, and the position shown on the outputs.
        p  = (e / DIV) % FRAME;
        ph = p % HT;
        pv = p / HT;
        if (e < DIV) begin
          expHs = 1'b1; expVs = 1'b1; expCol = 0;
        end else begin
          idx = (e / DIV - 1) % FRAME;
          h = idx % HT;
          v = idx / HT;
          expHs = !((h >= H_VIS + H_FP) && (h < H_VIS + H_FP + H_SYNC));
          expVs = !((v >= V_VIS + V_FP) && (v < V_VIS + V_FP + V_SYNC));
          expCol = inWin(h, v) ? int'(memArr[(v - Y0) * IMG_W + (h - X0)]) : 0;
        end
        // R1 R2: horizontal sync level every clock
        check(hSyncN === expHs, "R1 R2 hSyncN", int'(hSyncN), int'(expHs));
        // R1 R3: vertical sync level every clock
        check(vSyncN === expVs, "R1 R3 vSyncN", int'(vSyncN), int'(expVs));
        if (expCol == 0 && !(e >= DIV && inWin(h, v)))
          check({red, green, blue} === 12'h000, "R5 black outside window",
                int'({red, green, blue}), 0);
        else begin
          check(red === 4'(expCol >> 8), "R6 red field", int'(red), (expCol >> 8) & 15);
          check(green === 4'(expCol >> 4), "R6 green field", int'(green), (expCol >> 4) & 15);
          check(blue === 4'(expCol), "R6 blue field", int'(blue), expCol & 15);
        end
        if (inWin(ph, pv)) begin
          expAddr = (pv - Y0) * IMG_W + (ph - X0);
          check(memAddr === AW'(expAddr), "R7 window address", int'(memAddr), expAddr);
        end
        if (p == 0)
          check(memAddr === '0, "R8 address rewind at frame start", int'(memAddr), 0);
        check(int'(memAddr) < NPIX, "R8 address bound", int'(memAddr), NPIX - 1);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule